// File: doc/BRIEF.md
# Triangle-Count PWM with Double-Buffered Compare

This block produces one complementary PWM pair from an up/down counter that climbs from zero to a programmed period and then falls back to zero, over and over. The output is centre-aligned on the top of that triangle. The active compare value can be replaced twice per period: once when the count peaks (the crest) and once when it bottoms out (the trough). This lets the half-period before the crest and the half-period after it use different duty values, so the pulse can be placed off-centre.

A host programs the block through a small write-only register port. The duty values are staged in two steps. The host writes the trough value into buffer B first, then writes the crest value to buffer A. The write to buffer A moves both values into a pair of temporary registers in the same cycle. The counter then copies them into the active compare register at the next crest and trough. Two enable bits make the block emit a one-clock ADC start pulse at the crest, at the trough, or at both.

The control FSM has three states. ST_IDLE holds the count at zero. ST_UP increments. ST_DOWN decrements. Its transitions are:
- start: ST_IDLE to ST_UP when the run bit is set.
- crest turn: ST_UP to ST_DOWN when the count has reached the period.
- trough turn: ST_DOWN to ST_UP when the count is zero.
- stop: any running state to ST_IDLE when the run bit is cleared. The count returns to zero.

Top module: `tri_pwm_dbuf`

## Requirements
- R1: After reset the count is idle at zero and the run bit is clear. The compare value and both temporaries are zero. pwm_p is 0, pwm_n is 1, and both trigger outputs are 0.
- R2: While running, the count goes 0,1,…,P in ST_UP and then P-1,…,0 in ST_DOWN, so one full cycle lasts 2·P clocks. The crest is the clock in ST_UP with count ≥ P. The trough is the clock in ST_DOWN with count 0. P is the period register and must be at least 2.
- R3: A write to buffer A (address 1) loads the written value into temporary A. In the same cycle it loads the current buffer B content into temporary B. A write to buffer B (address 2) alone changes neither temporary, so it has no effect on the outputs until buffer A is written.
- R4: At the crest, temporary A is copied into the active compare register. From the next clock on, and one clock after each count value, pwm_p is 1 while the block is running and the count is at or above the compare value. When idle, pwm_p is 0.
- R5: With double-buffer mode on (control bit 1), temporary B is copied into the compare register at the trough. Equal buffers give a symmetric pulse. Over one full cycle with crest value a and trough value b, pwm_p is high for (#k in 1..P with k≥b) + (#k in 0..P-1 with k≥a) clocks.
- R6: With double-buffer mode off, temporary A is loaded at the trough as well. This gives a symmetric pulse of 2·(P−a)+1 high clocks for 0<a≤P.
- R7: With control bit 2 set, adc_trig_crest pulses high for exactly one clock, on the clock after each crest. With the bit clear, it stays 0.
- R8: With control bit 3 set, adc_trig_trough pulses high for exactly one clock, on the clock after each trough. With the bit clear, it stays 0.
- R9: If buffer A is written on the same clock as a crest or trough transfer, the transfer uses the temporary values held before that write. The new values take effect at the following crest or trough.
- R10: pwm_n is always the inverse of pwm_p.
- R11: The register map is: address 0 = period, 1 = buffer A, 2 = buffer B, 3 = control. The control bits are run (bit 0), double-buffer mode (bit 1), crest trigger enable (bit 2) and trough trigger enable (bit 3). A control write takes effect one clock after it is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | CNT_W | Register write data |
| pwm_p | output | 1 | Positive PWM output |
| pwm_n | output | 1 | Negative (inverted) PWM output |
| adc_trig_crest | output | 1 | One-clock ADC start pulse at the crest |
| adc_trig_trough | output | 1 | One-clock ADC start pulse at the trough |

## Verification
The properties assume that the period is at least 2 and is rewritten only while the run bit is clear. This keeps the crest and trough separated by several clocks and keeps the count from running past the period. The stimulus respects both limits. Every period change, random or directed, is made inside a stop, rewrite and restart sequence, and periods are drawn from 2 to 9. Buffer values are drawn from 0 to P+1, so the fully-low and fully-high extremes are reached without breaking these assumptions.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } tri_state_e;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_PERIOD = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_BUF_A  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_BUF_B  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd3;

    localparam int CTRL_W       = 4;
    localparam int CB_RUN       = 0;
    localparam int CB_DOUBLE    = 1;
    localparam int CB_TRG_CREST = 2;
    localparam int CB_TRG_TROUGH = 3;

    localparam int N_TRIG = 2;
    localparam int TRIG_CREST  = 0;
    localparam int TRIG_TROUGH = 1;

endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
    import tpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [W-1:0]        wr_data,
    output logic [W-1:0]        period_o,
    output logic [W-1:0]        tmp_a_o,
    output logic [W-1:0]        tmp_b_o,
    output logic [CTRL_W-1:0]   ctrl_o
);

    logic [W-1:0] stage_b_q;

    // Staging: buffer B waits; a write to buffer A commits both temporaries (R3, R11)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_o  <= '0;
            stage_b_q <= '0;
            tmp_a_o   <= '0;
            tmp_b_o   <= '0;
            ctrl_o    <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADR_PERIOD: period_o  <= wr_data;
                ADR_BUF_A: begin
                    tmp_a_o <= wr_data;
                    tmp_b_o <= stage_b_q;
                end
                ADR_BUF_B:  stage_b_q <= wr_data;
                ADR_CTRL:   ctrl_o    <= wr_data[CTRL_W-1:0];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/tpwm_counter.sv
module tpwm_counter
    import tpwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] period_i,
    output tri_state_e   state_o,
    output logic [W-1:0] cnt_o,
    output logic         crest_o,
    output logic         trough_o
);

    tri_state_e   state_d;
    logic [W-1:0] cnt_d;

    // Turn-point events seen from the registered count (R2)
    assign crest_o  = (state_o == ST_UP)   && (cnt_o >= period_i);
    assign trough_o = (state_o == ST_DOWN) && (cnt_o == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_o <= ST_IDLE;
            cnt_o   <= '0;
        end else begin
            state_o <= state_d;
            cnt_o   <= cnt_d;
        end
    end

    // Transitions: start, crest turn, trough turn, stop
    always_comb begin
        state_d = state_o;
        cnt_d   = cnt_o;
        unique case (state_o)
            ST_IDLE: begin
                cnt_d = '0;
                if (run_i) state_d = ST_UP;
            end
            ST_UP: begin
                if (!run_i) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (crest_o) begin
                    state_d = ST_DOWN;
                    cnt_d   = cnt_o - 1'b1;
                end else begin
                    cnt_d = cnt_o + 1'b1;
                end
            end
            ST_DOWN: begin
                if (!run_i) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (trough_o) begin
                    state_d = ST_UP;
                    cnt_d   = cnt_o + 1'b1;
                end else begin
                    cnt_d = cnt_o - 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

endmodule

// File: rtl/tpwm_compare.sv
module tpwm_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         crest_i,
    input  logic         trough_i,
    input  logic         double_i,
    input  logic [W-1:0] tmp_a_i,
    input  logic [W-1:0] tmp_b_i,
    output logic [W-1:0] cmp_o
);

    // Crest loads temporary A; trough loads B in double mode, else A (R4, R5, R6)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_o <= '0;
        end else if (crest_i) begin
            cmp_o <= tmp_a_i;
        end else if (trough_i) begin
            cmp_o <= double_i ? tmp_b_i : tmp_a_i;
        end
    end

endmodule

// File: rtl/tri_pwm_dbuf.sv
module tri_pwm_dbuf
    import tpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    output logic                 pwm_p,
    output logic                 pwm_n,
    output logic                 adc_trig_crest,
    output logic                 adc_trig_trough
);

    logic [CNT_W-1:0]  period_q;
    logic [CNT_W-1:0]  tmp_a_q;
    logic [CNT_W-1:0]  tmp_b_q;
    logic [CTRL_W-1:0] ctrl_q;
    tri_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic              crest_evt;
    logic              trough_evt;
    logic [CNT_W-1:0]  cmp_q;
    logic [N_TRIG-1:0] trig_evt;
    logic [N_TRIG-1:0] trig_en;
    logic [N_TRIG-1:0] trig_q;

    tpwm_regs #(.W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .period_o (period_q),
        .tmp_a_o  (tmp_a_q),
        .tmp_b_o  (tmp_b_q),
        .ctrl_o   (ctrl_q)
    );

    tpwm_counter #(.W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (ctrl_q[CB_RUN]),
        .period_i (period_q),
        .state_o  (state),
        .cnt_o    (cnt),
        .crest_o  (crest_evt),
        .trough_o (trough_evt)
    );

    tpwm_compare #(.W(CNT_W)) u_compare (
        .clk      (clk),
        .rst_n    (rst_n),
        .crest_i  (crest_evt),
        .trough_i (trough_evt),
        .double_i (ctrl_q[CB_DOUBLE]),
        .tmp_a_i  (tmp_a_q),
        .tmp_b_i  (tmp_b_q),
        .cmp_o    (cmp_q)
    );

    assign trig_evt[TRIG_CREST]  = crest_evt;
    assign trig_evt[TRIG_TROUGH] = trough_evt;
    assign trig_en[TRIG_CREST]   = ctrl_q[CB_TRG_CREST];
    assign trig_en[TRIG_TROUGH]  = ctrl_q[CB_TRG_TROUGH];

    // One registered pulse per enabled turn-point event (R7, R8)
    for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) trig_q[g] <= 1'b0;
            else        trig_q[g] <= trig_evt[g] & trig_en[g];
        end
    end

    // Output process: complementary pair from count versus compare (R4, R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_p <= 1'b0;
            pwm_n <= 1'b1;
        end else begin
            pwm_p <= (state != ST_IDLE) && (cnt >= cmp_q);
            pwm_n <= !((state != ST_IDLE) && (cnt >= cmp_q));
        end
    end

    assign adc_trig_crest  = trig_q[TRIG_CREST];
    assign adc_trig_trough = trig_q[TRIG_TROUGH];

endmodule

// File: rtl/tpwm_checker.sv
module tpwm_checker
    import tpwm_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_p,
    input logic              pwm_n,
    input logic              trig_c,
    input logic              trig_t,
    input tri_state_e        state,
    input logic [W-1:0]      cnt,
    input logic              crest,
    input logic              trough,
    input logic [W-1:0]      cmp,
    input logic [W-1:0]      tmp_a,
    input logic [W-1:0]      tmp_b,
    input logic [CTRL_W-1:0] ctrl
);

    p_complement_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_n == !pwm_p);

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !pwm_p);

    p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UP && !crest && ctrl[CB_RUN]) |=> (cnt == W'($past(cnt) + 1'b1)));

    p_down_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOWN && !trough && ctrl[CB_RUN]) |=> (cnt == W'($past(cnt) - 1'b1)));

    p_crest_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        crest |=> (cmp == $past(tmp_a)));

    p_trough_dbl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trough && ctrl[CB_DOUBLE]) |=> (cmp == $past(tmp_b)));

    p_trough_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trough && !ctrl[CB_DOUBLE]) |=> (cmp == $past(tmp_a)));

    p_crest_trig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (crest && ctrl[CB_TRG_CREST]) |=> trig_c);

    p_crest_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_c |=> !trig_c);

    p_trough_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trough && ctrl[CB_TRG_TROUGH]) |=> trig_t);

    p_trough_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_t |=> !trig_t);

    p_hold_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!crest && !trough) |=> $stable(cmp));

endmodule

bind tri_pwm_dbuf tpwm_checker #(.W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwm_p  (pwm_p),
    .pwm_n  (pwm_n),
    .trig_c (adc_trig_crest),
    .trig_t (adc_trig_trough),
    .state  (state),
    .cnt    (cnt),
    .crest  (crest_evt),
    .trough (trough_evt),
    .cmp    (cmp_q),
    .tmp_a  (tmp_a_q),
    .tmp_b  (tmp_b_q),
    .ctrl   (ctrl_q)
);

// File: tb/tri_pwm_dbuf_bench.sv
module tri_pwm_dbuf_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W = 16;
    localparam int S_IDLE = 0, S_UP = 1, S_DOWN = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_p, pwm_n, adc_trig_crest, adc_trig_trough;

    int checks = 0;
    int fails  = 0;
    string phase = "R1";
    logic done = 1'b0;

    always #10 clk = ~clk;

    tri_pwm_dbuf #(.CNT_W(W)) u_tri_pwm_dbuf (
        .clk             (clk),
        .rst_n           (rst_n),
        .wr_en           (wr_en),
        .wr_addr         (wr_addr),
        .wr_data         (wr_data),
        .pwm_p           (pwm_p),
        .pwm_n           (pwm_n),
        .adc_trig_crest  (adc_trig_crest),
        .adc_trig_trough (adc_trig_trough)
    );

    // Reference model built from the requirements
    int           m_st;
    logic [W-1:0] m_cnt, m_per, m_cmp, m_ta, m_tb, m_bb;
    logic [3:0]   m_ctrl;
    logic         e_p, e_tc, e_tt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = S_IDLE; m_cnt = '0; m_per = '0; m_cmp = '0;
            m_ta = '0; m_tb = '0; m_bb = '0; m_ctrl = '0;
            e_p = 1'b0; e_tc = 1'b0; e_tt = 1'b0;
        end else begin
            logic crest, trough;
            crest  = (m_st == S_UP) && (m_cnt >= m_per);
            trough = (m_st == S_DOWN) && (m_cnt == '0);
            e_p  = (m_st != S_IDLE) && (m_cnt >= m_cmp);
            e_tc = crest && m_ctrl[2];
            e_tt = trough && m_ctrl[3];
            if (crest) m_cmp = m_ta;
            else if (trough) m_cmp = m_ctrl[1] ? m_tb : m_ta;
            case (m_st)
                S_IDLE: if (m_ctrl[0]) m_st = S_UP;
                S_UP: begin
                    if (!m_ctrl[0]) begin m_st = S_IDLE; m_cnt = '0; end
                    else if (crest) begin m_st = S_DOWN; m_cnt = m_cnt - 1'b1; end
                    else m_cnt = m_cnt + 1'b1;
                end
                default: begin
                    if (!m_ctrl[0]) begin m_st = S_IDLE; m_cnt = '0; end
                    else if (trough) begin m_st = S_UP; m_cnt = m_cnt + 1'b1; end
                    else m_cnt = m_cnt - 1'b1;
                end
            endcase
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_per = wr_data;
                    2'd1: begin m_ta = wr_data; m_tb = m_bb; end
                    2'd2: m_bb = wr_data;
                    default: m_ctrl = wr_data[3:0];
                endcase
            end
        end
    end

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check1(phase, "pwm_p", pwm_p, e_p);
            check1("R10", "pwm_n", pwm_n, !e_p);
            check1("R7", "adc_trig_crest", adc_trig_crest, e_tc);
            check1("R8", "adc_trig_trough", adc_trig_trough, e_tt);
        end
    end

    function automatic int high_per_cycle(int p, int a, int b);
        int h = 0;
        for (int k = 1; k <= p; k++) if (k >= b) h++;
        for (int k = 0; k < p; k++) if (k >= a) h++;
        return h;
    endfunction

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_p) h++;
        end
    endtask

    task automatic check_int(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic restart(input int p, input int ctrl);
        wr(2'd3, 0);
        wr(2'd0, p);
        wr(2'd3, ctrl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int h;
        void'($urandom(32'd4242));
        // R1: reset state
        repeat (3) @(negedge clk);
        check1("R1", "pwm_p in reset", pwm_p, 1'b0);
        check1("R1", "pwm_n in reset", pwm_n, 1'b1);
        check1("R1", "crest trig in reset", adc_trig_crest, 1'b0);
        check1("R1", "trough trig in reset", adc_trig_trough, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check1("R1", "pwm_p idle", pwm_p, 1'b0);

        // R11 and R4: program and start, symmetric duty
        phase = "R11";
        wr(2'd0, 6);
        wr(2'd2, 3);
        wr(2'd1, 3);
        wr(2'd3, 4'hF);
        repeat (30) @(negedge clk);
        phase = "R4";
        count_high(12, h);
        check_int("R4", "symmetric high clocks", h, high_per_cycle(6, 3, 3));

        // R5: asymmetric, crest value 2, trough value 4
        phase = "R5";
        wr(2'd2, 4);
        wr(2'd1, 2);
        repeat (30) @(negedge clk);
        count_high(12, h);
        check_int("R5", "asymmetric high clocks", h, high_per_cycle(6, 2, 4));

        // R6: single buffer mode, triggers off (R7/R8 disabled)
        phase = "R6";
        wr(2'd3, 4'h1);
        repeat (30) @(negedge clk);
        count_high(12, h);
        check_int("R6", "single-mode high clocks", h, 2 * (6 - 2) + 1);

        // R3: buffer B alone changes nothing
        phase = "R3";
        wr(2'd3, 4'hF);
        wr(2'd2, 0);
        repeat (30) @(negedge clk);
        count_high(12, h);
        check_int("R3", "B-only write ignored", h, high_per_cycle(6, 2, 4));

        // R9: buffer A written exactly on a crest clock
        phase = "R9";
        wr(2'd2, 5);
        @(negedge clk);
        while (!(m_st == S_UP && m_cnt >= m_per)) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = W'(5);
        @(negedge clk);
        wr_en = 1'b0;
        repeat (30) @(negedge clk);
        @(negedge clk);
        while (!(m_st == S_DOWN && m_cnt == '0)) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = W'(1);
        @(negedge clk);
        wr_en = 1'b0;
        repeat (30) @(negedge clk);

        // R2: boundary period 2 and buffers 0 and P+1
        phase = "R2";
        restart(2, 4'hF);
        wr(2'd2, 3);
        wr(2'd1, 0);
        repeat (20) @(negedge clk);
        count_high(4, h);
        check_int("R2", "period 2 high clocks", h, high_per_cycle(2, 0, 3));

        // Random phase
        phase = "R4 R5 R6 random";
        for (int it = 0; it < 60; it++) begin
            int op = $urandom_range(0, 4);
            int p  = int'(m_per);
            case (op)
                0: begin wr(2'd2, $urandom_range(0, p + 1)); wr(2'd1, $urandom_range(0, p + 1)); end
                1: wr(2'd1, $urandom_range(0, p + 1));
                2: wr(2'd2, $urandom_range(0, p + 1));
                3: wr(2'd3, 1 + 2 * $urandom_range(0, 7));
                default: restart($urandom_range(2, 9), 1 + 2 * $urandom_range(0, 7));
            endcase
            repeat ($urandom_range(1, 3 * 9)) @(negedge clk);
        end

        // Stop returns to idle
        phase = "R1";
        wr(2'd3, 0);
        repeat (3) @(negedge clk);
        check1("R1", "pwm_p after stop", pwm_p, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule